// File: doc/BRIEF.md
# Calendar Real-Time Clock with Guarded Setup

This block keeps the time of day and a calendar date for a chip that has a slow timing reference. The reference reaches the block as a one-cycle enable pulse, `tick_en_i`, in the fast clock domain. A two-stage divider turns those pulses into one calendar step per second. Time and date are held in packed BCD. The calendar carries seconds into minutes, hours, days, months and a two-digit year. It uses true month lengths and a divisible-by-four leap-year rule.

Software reaches the block through a small word-addressed register port. All register writes are refused until a two-byte key has been written to the key register. Time, date and divider values are also refused unless init mode has been requested and acknowledged. While init mode is held, the calendar does not advance. Time and date reads return shadow copies. These copies refresh after every calendar step and when init mode ends, and a sync flag marks each refresh. A combinational output packs the live calendar into a 32-bit file-system timestamp.

Register word addresses: 0 time, 1 date, 2 status, 3 control, 4 divider, 5 key (the key register reads as zero).

Top module: `rtc_cal`

## Requirements
- R1: After reset the time register reads 0x00000000, and the date register reads 0x00002101 (year 00, weekday 1, month 01, day 01). The divider register reads 0x007F00FF, the status and control registers read 0, and the timestamp output equals (20<<25)|(1<<21)|(1<<16).
- R2: Writes to address 5 move the lock state. 0xCA arms it. 0x53 written right after 0xCA opens it. Any other byte, or any key write while open, locks it again (0xCA re-arms it). While the lock is not open, writes to the status, control, time, date and divider registers have no effect.
- R3: Status bit 0 is the init request. Status bit 1 is the acknowledge: it reads 1 one clock after the request is set and 0 one clock after the request is cleared. Writes to time, date and divider take effect only while the acknowledge is 1.
- R4: While the acknowledge is 1, enable pulses do not advance the calendar and the divider counters are held at zero. After bit 0 is cleared, counting resumes from the loaded values.
- R5: The divider register holds (A−1) in bits 22:16 and (S−1) in bits 14:0. One second passes on every A·S-th enable pulse counted from the end of init mode.
- R6: Control bit 0 set to 1 freezes the divider and calendar. Clearing it resumes counting.
- R7: The time register holds BCD seconds in bits 6:0, minutes in 14:8 and hours in 21:16. Seconds roll 59→00 into minutes, minutes roll 59→00 into hours, and hours roll 23→00 into the date.
- R8: The date register holds BCD day in bits 5:0, month in 12:8, weekday in 15:13 and year in 23:16. The day rolls to 01 after 30 in April, June, September and November, and after 31 in the other long months. Month 12 rolls to 01 with a year carry, year 99 rolls to 00, and the weekday steps 1..7 and wraps to 1.
- R9: February ends on day 29 when the year value is divisible by 4 and on day 28 otherwise.
- R10: Status bit 2 reads 0 until time or date has been loaded, then reads 1.
- R11: Status bit 3 is set when the shadow copies refresh, which happens after each second step and after init mode ends. A status write with bit 3 = 0 clears it, and a write with bit 3 = 1 leaves it. Time and date reads return the shadow copies.
- R12: `stamp_o` gives binary seconds/2 in bits 4:0, minutes in 10:5, hours in 15:11, day in 20:16, month in 24:21 and year+20 in 31:25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and logic clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_en_i | input | 1 | One-cycle pulse per period of the slow reference |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| stamp_o | output | 32 | Packed file-system timestamp of the live calendar |

## Verification
The bench goes after the carry chain at its edges: hour and year wrap, 30-day months, and February in leap and common years. A design with a wrong month table or leap rule lands on the wrong day, and one with bad BCD carries shows digits such as 0x0A. It also tests the lock with a broken key sequence and a key written after unlock. A permissive lock would let ignored control writes read back. A divider off by one shows up when the bench counts enable pulses: one fewer than A·S must not step the seconds, and exactly A·S must. Init mode, the hold bit and the sync flag are checked for frozen counting and for refresh after exit, and the timestamp is compared field by field.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  typedef enum logic [1:0] {KEY_SHUT, KEY_ARMED, KEY_OPEN} key_st_e;

  localparam logic [2:0] ADR_TIME  = 3'd0;
  localparam logic [2:0] ADR_DATE  = 3'd1;
  localparam logic [2:0] ADR_STAT  = 3'd2;
  localparam logic [2:0] ADR_CTRL  = 3'd3;
  localparam logic [2:0] ADR_DIV   = 3'd4;
  localparam logic [2:0] ADR_KEY   = 3'd5;

  localparam logic [7:0] KEY_FIRST  = 8'hCA;
  localparam logic [7:0] KEY_SECOND = 8'h53;

  function automatic logic [6:0] bcd2bin(input logic [7:0] b);
    return ({3'd0, b[7:4]} * 7'd10) + {3'd0, b[3:0]};
  endfunction

  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [5:0] month_len(input logic [4:0] mon, input logic [7:0] yr);
    logic [6:0] yb;
    yb = bcd2bin(yr);
    case (mon)
      5'h02: return (yb[1:0] == 2'd0) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default: return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_cal_guard.sv
module rtc_cal_guard
  import rtc_cal_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_wr_i,
  input  logic [7:0] key_byte_i,
  input  logic       stat_wr_i,
  input  logic       req_bit_i,
  output logic       open_o,
  output logic       init_req_o,
  output logic       init_ack_o,
  output logic       exit_o
);
  key_st_e st_q, st_d;
  logic    req_q, ack_q;

  always_comb begin
    st_d = st_q;
    if (key_wr_i) begin
      if (st_q == KEY_ARMED && key_byte_i == KEY_SECOND) st_d = KEY_OPEN;
      else if (key_byte_i == KEY_FIRST)                 st_d = KEY_ARMED;
      else                                              st_d = KEY_SHUT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= KEY_SHUT;
      req_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (stat_wr_i && st_q == KEY_OPEN) req_q <= req_bit_i;
      ack_q <= req_q;
    end
  end

  assign open_o     = (st_q == KEY_OPEN);
  assign init_req_o = req_q;
  assign init_ack_o = ack_q;
  assign exit_o     = ack_q & ~req_q;
endmodule

// File: rtl/rtc_cal_presc.sv
module rtc_cal_presc #(
  parameter int A_W = 7,
  parameter int S_W = 15
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           en_i,
  input  logic [A_W-1:0] a_div_i,
  input  logic [S_W-1:0] s_div_i,
  output logic           sec_o
);
  logic [A_W-1:0] a_cnt_q;
  logic [S_W-1:0] s_cnt_q;
  logic           a_wrap, s_wrap;

  assign a_wrap = (a_cnt_q == a_div_i);
  assign s_wrap = (s_cnt_q == s_div_i);
  assign sec_o  = en_i & ~clr_i & a_wrap & s_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_cnt_q <= '0;
      s_cnt_q <= '0;
    end else if (clr_i) begin
      a_cnt_q <= '0;
      s_cnt_q <= '0;
    end else if (en_i) begin
      if (a_wrap) begin
        a_cnt_q <= '0;
        s_cnt_q <= s_wrap ? '0 : s_cnt_q + 1'b1;
      end else begin
        a_cnt_q <= a_cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_cal_clock.sv
module rtc_cal_clock
  import rtc_cal_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        ld_time_i,
  input  logic        ld_date_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] time_o,
  output logic [31:0] date_o
);
  logic [6:0] sec_q, min_q;
  logic [5:0] hr_q, day_q;
  logic [4:0] mon_q;
  logic [2:0] wd_q;
  logic [7:0] yr_q;

  logic       sec_w, min_w, hr_w, day_w, mon_w;
  logic [7:0] sec_n, min_n, hr_n, day_n, mon_n, yr_n;
  logic [5:0] mlen;

  always_comb begin
    mlen  = month_len(mon_q, yr_q);
    sec_w = (sec_q == 7'h59);
    min_w = (min_q == 7'h59);
    hr_w  = (hr_q  == 6'h23);
    day_w = (day_q == mlen);
    mon_w = (mon_q == 5'h12);
    sec_n = bcd_step({1'b0, sec_q});
    min_n = bcd_step({1'b0, min_q});
    hr_n  = bcd_step({2'b0, hr_q});
    day_n = bcd_step({2'b0, day_q});
    mon_n = bcd_step({3'b0, mon_q});
    yr_n  = (yr_q == 8'h99) ? 8'h00 : bcd_step(yr_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= '0;
    end else if (ld_time_i) begin
      sec_q <= wdata_i[6:0];
      min_q <= wdata_i[14:8];
      hr_q  <= wdata_i[21:16];
    end else if (tick_i) begin
      sec_q <= sec_w ? 7'h00 : sec_n[6:0];
      if (sec_w) begin
        min_q <= min_w ? 7'h00 : min_n[6:0];
        if (min_w) hr_q <= hr_w ? 6'h00 : hr_n[5:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      day_q <= 6'h01;
      mon_q <= 5'h01;
      wd_q  <= 3'd1;
      yr_q  <= 8'h00;
    end else if (ld_date_i) begin
      day_q <= wdata_i[5:0];
      mon_q <= wdata_i[12:8];
      wd_q  <= wdata_i[15:13];
      yr_q  <= wdata_i[23:16];
    end else if (tick_i && sec_w && min_w && hr_w) begin
      wd_q  <= (wd_q == 3'd7) ? 3'd1 : wd_q + 3'd1;
      day_q <= day_w ? 6'h01 : day_n[5:0];
      if (day_w) begin
        mon_q <= mon_w ? 5'h01 : mon_n[4:0];
        if (mon_w) yr_q <= yr_n;
      end
    end
  end

  assign time_o = {10'd0, hr_q, 1'b0, min_q, 1'b0, sec_q};
  assign date_o = {8'd0, yr_q, wd_q, mon_q, 2'd0, day_q};
endmodule

// File: rtl/rtc_cal.sv
module rtc_cal
  import rtc_cal_pkg::*;
#(
  parameter int A_W   = 7,
  parameter int S_W   = 15,
  parameter int A_RST = 127,
  parameter int S_RST = 255
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_en_i,
  input  logic        wr_en_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic [31:0] stamp_o
);
  localparam logic [A_W-1:0] A_INIT = A_W'(A_RST);
  localparam logic [S_W-1:0] S_INIT = S_W'(S_RST);
  localparam logic [31:0]    DATE_RST = 32'h0000_2101;

  logic        open, init_req, init_ack, init_exit;
  logic        stat_wr, ctrl_wr, key_wr;
  logic        ld_time, ld_date, ld_div;
  logic        sec_tick, hold_q, set_once_q, sync_q, upd_q;
  logic [A_W-1:0] a_div_q;
  logic [S_W-1:0] s_div_q;
  logic [31:0] time_live, date_live, time_sh, date_sh;

  assign key_wr  = wr_en_i && addr_i == ADR_KEY;
  assign stat_wr = wr_en_i && addr_i == ADR_STAT;
  assign ctrl_wr = wr_en_i && addr_i == ADR_CTRL && open;
  assign ld_time = wr_en_i && addr_i == ADR_TIME && open && init_ack;
  assign ld_date = wr_en_i && addr_i == ADR_DATE && open && init_ack;
  assign ld_div  = wr_en_i && addr_i == ADR_DIV  && open && init_ack;

  rtc_cal_guard u_guard (
    .clk_i, .rst_ni,
    .key_wr_i   (key_wr),
    .key_byte_i (wdata_i[7:0]),
    .stat_wr_i  (stat_wr),
    .req_bit_i  (wdata_i[0]),
    .open_o     (open),
    .init_req_o (init_req),
    .init_ack_o (init_ack),
    .exit_o     (init_exit)
  );

  rtc_cal_presc #(.A_W(A_W), .S_W(S_W)) u_presc (
    .clk_i, .rst_ni,
    .clr_i   (init_ack),
    .en_i    (tick_en_i & ~hold_q),
    .a_div_i (a_div_q),
    .s_div_i (s_div_q),
    .sec_o   (sec_tick)
  );

  rtc_cal_clock u_clock (
    .clk_i, .rst_ni,
    .tick_i    (sec_tick),
    .ld_time_i (ld_time),
    .ld_date_i (ld_date),
    .wdata_i   (wdata_i),
    .time_o    (time_live),
    .date_o    (date_live)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_div_q    <= A_INIT;
      s_div_q    <= S_INIT;
      hold_q     <= 1'b0;
      set_once_q <= 1'b0;
      sync_q     <= 1'b0;
      upd_q      <= 1'b0;
      time_sh    <= '0;
      date_sh    <= DATE_RST;
    end else begin
      if (ld_div) begin
        a_div_q <= wdata_i[16 +: A_W];
        s_div_q <= wdata_i[0 +: S_W];
      end
      if (ctrl_wr) hold_q <= wdata_i[0];
      if (ld_time || ld_date) set_once_q <= 1'b1;
      upd_q <= sec_tick | init_exit;
      if (upd_q) begin
        time_sh <= time_live;
        date_sh <= date_live;
        sync_q  <= 1'b1;
      end else if (stat_wr && open && !wdata_i[3]) begin
        sync_q  <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_TIME: rdata_o = time_sh;
      ADR_DATE: rdata_o = date_sh;
      ADR_STAT: rdata_o = {28'd0, sync_q, set_once_q, init_ack, init_req};
      ADR_CTRL: rdata_o = {31'd0, hold_q};
      ADR_DIV: begin
        rdata_o[16 +: A_W] = a_div_q;
        rdata_o[0 +: S_W]  = s_div_q;
      end
      default: rdata_o = '0;
    endcase
  end

  logic [6:0] sec_b, min_b, hr_b, day_b, mon_b, yr_b;
  always_comb begin
    sec_b = bcd2bin({1'b0, time_live[6:0]});
    min_b = bcd2bin({1'b0, time_live[14:8]});
    hr_b  = bcd2bin({2'b0, time_live[21:16]});
    day_b = bcd2bin({2'b0, date_live[5:0]});
    mon_b = bcd2bin({3'b0, date_live[12:8]});
    yr_b  = bcd2bin(date_live[23:16]) + 7'd20;
    stamp_o = {yr_b, mon_b[3:0], day_b[4:0], hr_b[4:0], min_b[5:0], sec_b[5:1]};
  end
endmodule

// File: rtl/rtc_cal_chk.sv
module rtc_cal_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        init_req,
  input logic        init_ack,
  input logic        sec_tick,
  input logic        ld_time,
  input logic        ld_date,
  input logic        upd_q,
  input logic        sync_q,
  input logic [31:0] time_live
);
  p_ack_after_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_req) |=> init_ack);

  p_no_load_outside_init_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_ack |-> !(ld_time || ld_date));

  p_frozen_in_init_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_ack |-> !sec_tick);

  p_sec_roll_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick && time_live[6:0] == 7'h59) |=> time_live[6:0] == 7'h00);

  p_sync_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |=> sync_q);
endmodule

bind rtc_cal rtc_cal_chk u_chk (
  .clk_i, .rst_ni, .init_req, .init_ack, .sec_tick,
  .ld_time, .ld_date, .upd_q, .sync_q, .time_live
);

// File: tb/rtc_cal_tb_top.sv
module rtc_cal_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, stamp;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_cal dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .stamp_o(stamp)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic unlock();
    wr(3'd5, 32'hCA);
    wr(3'd5, 32'h53);
  endtask

  task automatic enter_init();
    logic [31:0] s;
    wr(3'd2, 32'h9);
    for (int i = 0; i < 8; i++) begin
      rd(3'd2, s);
      if (s[1]) break;
    end
  endtask

  task automatic set_cal(input logic [31:0] dv, input logic [31:0] t, input logic [31:0] d);
    enter_init();
    wr(3'd4, dv);
    wr(3'd0, t);
    wr(3'd1, d);
    wr(3'd2, 32'h8);
    repeat (3) @(negedge clk);
  endtask

  task automatic step_case(input string req, input logic [31:0] t, input logic [31:0] d,
                           input logic [31:0] te, input logic [31:0] de);
    logic [31:0] v;
    set_cal(32'h0, t, d);
    pulse(1);
    rd(3'd0, v); check(req, v, te);
    rd(3'd1, v); check(req, v, de);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); check("R1 time", v, 32'h0);
    rd(3'd1, v); check("R1 date", v, 32'h0000_2101);
    rd(3'd2, v); check("R1 stat", v, 32'h0);
    rd(3'd3, v); check("R1 ctrl", v, 32'h0);
    rd(3'd4, v); check("R1 div", v, 32'h007F_00FF);
    check("R1 stamp", stamp, (32'd20 << 25) | (32'd1 << 21) | (32'd1 << 16));
  endtask

  task automatic t_locked();
    logic [31:0] v;
    wr(3'd2, 32'h1);
    repeat (2) @(negedge clk);
    rd(3'd2, v); check("R2 locked stat", v, 32'h0);
    wr(3'd3, 32'h1);
    rd(3'd3, v); check("R2 locked ctrl", v, 32'h0);
    wr(3'd5, 32'hCA); wr(3'd5, 32'h11); wr(3'd5, 32'h53);
    wr(3'd3, 32'h1);
    rd(3'd3, v); check("R2 bad key", v, 32'h0);
    unlock();
    wr(3'd3, 32'h1);
    rd(3'd3, v); check("R2 open ctrl", v, 32'h1);
    wr(3'd3, 32'h0);
  endtask

  task automatic t_init();
    logic [31:0] v;
    wr(3'd0, 32'h0012_1212);
    repeat (2) @(negedge clk);
    rd(3'd0, v); check("R3 no init load", v, 32'h0);
    rd(3'd2, v); check("R10 not set", {31'd0, v[2]}, 32'h0);
    wr(3'd2, 32'h9);
    rd(3'd2, v); check("R3 ack", v & 32'h3, 32'h3);
    wr(3'd4, 32'h0);
    wr(3'd0, 32'h0010_1010);
    pulse(5);
    wr(3'd2, 32'h8);
    rd(3'd2, v); check("R3 ack drop", v & 32'h3, 32'h0);
    repeat (3) @(negedge clk);
    rd(3'd0, v); check("R4 frozen in init", v, 32'h0010_1010);
    rd(3'd2, v); check("R10 set once", {31'd0, v[2]}, 32'h1);
    pulse(1);
    rd(3'd0, v); check("R4 resume", v, 32'h0010_1011);
  endtask

  task automatic t_roll();
    step_case("R7 min carry", 32'h0010_0959, 32'h0023_2415, 32'h0010_1000, 32'h0023_2415);
    step_case("R7 hour carry", 32'h0009_5959, 32'h0023_2415, 32'h0010_0000, 32'h0023_2415);
    step_case("R8 year end", 32'h0023_5959, 32'h0023_F231, 32'h0, 32'h0024_2101);
    step_case("R8 30-day", 32'h0023_5959, 32'h0023_2430, 32'h0, 32'h0023_4501);
    step_case("R8 year 99", 32'h0023_5959, 32'h0099_3231, 32'h0, 32'h0000_4101);
    step_case("R9 leap", 32'h0023_5959, 32'h0024_6228, 32'h0, 32'h0024_8229);
    step_case("R9 common", 32'h0023_5959, 32'h0023_6228, 32'h0, 32'h0023_8301);
  endtask

  task automatic t_div();
    logic [31:0] v;
    set_cal(32'h0002_0003, 32'h0001_0000, 32'h0023_2101);
    rd(3'd4, v); check("R5 div reg", v, 32'h0002_0003);
    pulse(11);
    rd(3'd0, v); check("R5 A*S-1 pulses", v, 32'h0001_0000);
    pulse(1);
    rd(3'd0, v); check("R5 A*S pulses", v, 32'h0001_0001);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    set_cal(32'h0, 32'h0002_0000, 32'h0023_2101);
    wr(3'd3, 32'h1);
    pulse(3);
    rd(3'd0, v); check("R6 hold", v, 32'h0002_0000);
    wr(3'd3, 32'h0);
    pulse(1);
    rd(3'd0, v); check("R6 release", v, 32'h0002_0001);
  endtask

  task automatic t_sync();
    logic [31:0] v;
    wr(3'd2, 32'h8);
    rd(3'd2, v); check("R11 keep on 1", {31'd0, v[3]}, 32'h1);
    wr(3'd2, 32'h0);
    rd(3'd2, v); check("R11 clear", {31'd0, v[3]}, 32'h0);
    pulse(1);
    rd(3'd2, v); check("R11 reset on step", {31'd0, v[3]}, 32'h1);
  endtask

  task automatic t_stamp();
    set_cal(32'h0, 32'h0013_4530, 32'h0023_2615);
    check("R12 stamp", stamp, (32'd43 << 25) | (32'd6 << 21) | (32'd15 << 16) |
                              (32'd13 << 11) | (32'd45 << 5) | 32'd15);
  endtask

  task automatic t_relock();
    logic [31:0] v;
    wr(3'd5, 32'hFF);
    wr(3'd3, 32'h1);
    rd(3'd3, v); check("R2 relock", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_init();
    t_roll();
    t_div();
    t_hold();
    t_sync();
    t_stamp();
    t_relock();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule